// File: doc/BRIEF.md
# Ternary Match Flow Classifier

This block is a small ternary content-addressable table used to sort packet keys into flows. A writer loads one entry at a time, giving its index, a key with a compare mask, a valid flag, an action word and an optional rule identifier. Internally each key bit is kept as a pair of bits (x, y). This pair encoding can express exact-0, exact-1, don't-care and a never-match state. A raw write mode stores the pair directly, so the never-match state can be loaded.

A search presents a key for one cycle. One cycle later the block reports whether any valid entry matched, the index of the lowest matching entry and that entry's decoded action. The action is either drop or forward to a queue, and the rule identifier is included if one was attached to the entry. A single clear pulse empties the whole table. The table depth, the key width, the queue-id width and the rule-id width are parameters.

Top module: `tcam_classifier`

## Requirements
- R1: In normal write mode (wr_raw=0), each key bit whose wr_mask bit is 1 must equal the search key bit for the entry to match, and each bit whose mask bit is 0 is ignored.
- R2: In raw write mode (wr_raw=1), wr_key is stored as x and wr_mask is stored as y for each bit. A pair (0,0) matches any input bit, (1,0) matches only 0, and (0,1) matches only 1.
- R3: A stored pair (1,1) never matches, so an entry holding it in any bit never hits.
- R4: An entry written with wr_valid=0 never hits, whatever its key.
- R5: When several valid entries match, res_idx reports the lowest index, and the action reported is that entry's action.
- R6: res_vld is high exactly in the cycle after a cycle with srch_en high, and low otherwise. The result outputs are registered.
- R7: On a miss, res_hit=0 and res_idx=0. The action is accept: res_drop=0, res_fwd=0, res_qid=0 and res_rid_vld=0.
- R8: The action word decodes as follows: bit 0 is drop, bit 1 is forward to a direct queue, and bits [2 +: QID_W] are the queue id.
- R9: An entry written with wr_rid_en=1 reports res_rid_vld=1 and its wr_rid value on a hit. An entry written with wr_rid_en=0 reports res_rid_vld=0.
- R10: clear_all invalidates every entry in one cycle. A write in the same cycle as clear_all is discarded.
- R11: A write and a search in the same cycle return the table contents from before the write. The new entry takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clear_all | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Write strobe |
| wr_raw | input | 1 | Store key/mask directly as x/y |
| wr_idx | input | IDX_W | Entry index to write |
| wr_key | input | KEY_W | Key (or x in raw mode) |
| wr_mask | input | KEY_W | Compare mask (or y in raw mode) |
| wr_valid | input | 1 | Valid flag for the entry |
| wr_action | input | QID_W+2 | Action word |
| wr_rid_en | input | 1 | Attach the rule id |
| wr_rid | input | RID_W | Rule id |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Search key |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | IDX_W | Lowest matching index |
| res_drop | output | 1 | Drop the packet |
| res_fwd | output | 1 | Forward to res_qid |
| res_qid | output | QID_W | Queue id |
| res_rid_vld | output | 1 | Rule id is attached |
| res_rid | output | RID_W | Rule id |

## Verification
The assertions assume that srch_en is held low during reset, so the first result pulse comes from a real search. They also assume that nothing except a search moves the result outputs. The clear check assumes that a search in the cycle right after clear_all sees an empty table; this holds even if a write happens in that same cycle, because of the old-contents rule. The bench drives every input on the falling edge and keeps srch_en low until reset is released. It never depends on the ordering of a clear and a write beyond the priority stated in R10.

// File: rtl/tcam_classifier.sv
module tcam_classifier #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 16,
  parameter int QID_W = 11,
  parameter int RID_W = 13,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ACT_W = QID_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic             wr_raw,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_valid,
  input  logic [ACT_W-1:0] wr_action,
  input  logic             wr_rid_en,
  input  logic [RID_W-1:0] wr_rid,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_vld,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic             res_drop,
  output logic             res_fwd,
  output logic [QID_W-1:0] res_qid,
  output logic             res_rid_vld,
  output logic [RID_W-1:0] res_rid
);

  logic [KEY_W-1:0] x_q   [DEPTH];
  logic [KEY_W-1:0] y_q   [DEPTH];
  logic [ACT_W-1:0] act_q [DEPTH];
  logic [RID_W-1:0] rid_q [DEPTH];
  logic [DEPTH-1:0] vld_q, rvld_q, hit_vec;
  logic [KEY_W-1:0] wx, wy;
  logic [IDX_W-1:0] sel;
  logic             any;
  logic             do_wr;

  assign wx    = wr_raw ? wr_key  : (~wr_key & wr_mask);
  assign wy    = wr_raw ? wr_mask : ((wr_key ^ ~wr_mask) & wr_key);
  assign do_wr = wr_en && !clear_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clear_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      x_q[wr_idx]    <= wx;
      y_q[wr_idx]    <= wy;
      act_q[wr_idx]  <= wr_action;
      rid_q[wr_idx]  <= wr_rid;
      rvld_q[wr_idx] <= wr_rid_en;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign hit_vec[e] = vld_q[e] &&
      ~|((x_q[e] & y_q[e]) | (x_q[e] & srch_key) | (y_q[e] & ~srch_key));
  end

  assign any = |hit_vec;

  always_comb begin
    sel = '0;
    for (int e = DEPTH - 1; e >= 0; e--)
      if (hit_vec[e]) sel = IDX_W'(e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      res_hit     <= 1'b0;
      res_idx     <= '0;
      res_drop    <= 1'b0;
      res_fwd     <= 1'b0;
      res_qid     <= '0;
      res_rid_vld <= 1'b0;
      res_rid     <= '0;
    end else begin
      res_vld <= srch_en;
      if (srch_en) begin
        res_hit     <= any;
        res_idx     <= any ? sel : '0;
        res_drop    <= any && act_q[sel][0];
        res_fwd     <= any && act_q[sel][1];
        res_qid     <= any ? act_q[sel][2 +: QID_W] : '0;
        res_rid_vld <= any && rvld_q[sel];
        res_rid     <= (any && rvld_q[sel]) ? rid_q[sel] : '0;
      end
    end
  end

endmodule

// File: rtl/tcam_classifier_chk.sv
module tcam_classifier_chk #(
  parameter int QID_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_all,
  input logic             srch_en,
  input logic             res_vld,
  input logic             res_hit,
  input logic             res_drop,
  input logic             res_fwd,
  input logic [QID_W-1:0] res_qid,
  input logic             res_rid_vld
);

  assert_vld_follows_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_vld);

  assert_no_spurious_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_vld);

  assert_miss_is_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (!res_drop && !res_fwd && res_qid == '0 && !res_rid_vld));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all ##1 srch_en) |=> !res_hit);

  assert_rid_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_rid_vld |-> res_hit);

endmodule

bind tcam_classifier tcam_classifier_chk #(.QID_W(QID_W)) u_chk (.*);

// File: tb/tcam_classifier_test.sv
`timescale 1ns/1ps
module tcam_classifier_test;
  localparam int DEPTH = 8, KEY_W = 16, QID_W = 11, RID_W = 13;
  localparam int IDX_W = $clog2(DEPTH), ACT_W = QID_W + 2;

  logic clk = 0, rst_n = 0, clear_all = 0, wr_en = 0, wr_raw = 0, wr_valid = 0;
  logic wr_rid_en = 0, srch_en = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [KEY_W-1:0] wr_key = '0, wr_mask = '0, srch_key = '0;
  logic [ACT_W-1:0] wr_action = '0;
  logic [RID_W-1:0] wr_rid = '0;
  logic res_vld, res_hit, res_drop, res_fwd, res_rid_vld;
  logic [IDX_W-1:0] res_idx;
  logic [QID_W-1:0] res_qid;
  logic [RID_W-1:0] res_rid;

  typedef struct {
    logic hit; int idx; logic drop; logic fwd; int qid; logic rv; int rid; string tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcam_classifier uut (.*);

  function automatic logic [ACT_W-1:0] act(input logic drop, input logic fwd, input int qid);
    return {QID_W'(qid), fwd, drop};
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, expv);
    end
  endtask

  task automatic wr(input int idx, input logic raw, input logic [KEY_W-1:0] k,
                    input logic [KEY_W-1:0] m, input logic v, input logic [ACT_W-1:0] a,
                    input logic ren, input int rid);
    @(negedge clk);
    wr_en = 1; wr_raw = raw; wr_idx = IDX_W'(idx); wr_key = k; wr_mask = m;
    wr_valid = v; wr_action = a; wr_rid_en = ren; wr_rid = RID_W'(rid);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic exp_t mk(input logic h, input int idx, input logic d, input logic f,
                              input int q, input logic rv, input int rid, input string tag);
    exp_t e;
    e.hit = h; e.idx = idx; e.drop = d; e.fwd = f; e.qid = q; e.rv = rv; e.rid = rid; e.tag = tag;
    return e;
  endfunction

  task automatic srch(input logic [KEY_W-1:0] k, input exp_t e);
    @(negedge clk);
    sb.push_back(e);
    srch_en = 1; srch_key = k;
    @(negedge clk);
    srch_en = 0;
  endtask

  function automatic exp_t miss(input string tag);
    return mk(0, 0, 0, 0, 0, 0, 0, tag);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "hit", res_hit, e.hit);
        chk(e.tag, "idx", res_idx, e.idx);
        chk(e.tag, "drop", res_drop, e.drop);
        chk(e.tag, "fwd", res_fwd, e.fwd);
        chk(e.tag, "qid", res_qid, e.qid);
        chk(e.tag, "rid_vld", res_rid_vld, e.rv);
        chk(e.tag, "rid", res_rid, e.rid);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6", "reset res_vld", res_vld, 0);
    chk("R7", "reset res_hit", res_hit, 0);

    // R1 R8 R9 exact match with rule id
    wr(3, 0, 16'hABCD, 16'hFFFF, 1, act(0, 1, 5), 1, 100);
    srch(16'hABCD, mk(1, 3, 0, 1, 5, 1, 100, "R1_R8_R9"));
    srch(16'hABCE, miss("R7"));
    // R1 partial mask, drop, no rule id
    wr(5, 0, 16'h1200, 16'hFF00, 1, act(1, 0, 0), 0, 77);
    srch(16'h12FF, mk(1, 5, 1, 0, 0, 0, 0, "R1_R9"));
    srch(16'h13FF, miss("R1"));
    // R5 lowest index wins
    wr(1, 0, 16'h1200, 16'hF000, 1, act(0, 1, 7), 0, 0);
    srch(16'h1234, mk(1, 1, 0, 1, 7, 0, 0, "R5"));
    srch(16'h1F00, mk(1, 1, 0, 1, 7, 0, 0, "R5"));
    // R2 raw pairs
    wr(0, 1, 16'h00FF, 16'hFF00, 1, act(1, 0, 0), 0, 0);
    srch(16'hFF00, mk(1, 0, 1, 0, 0, 0, 0, "R2"));
    srch(16'hFF01, miss("R2"));
    // R3 invalid pair in bit 0
    wr(0, 1, 16'h0001, 16'h0001, 1, act(0, 1, 9), 0, 0);
    srch(16'h0000, miss("R3"));
    srch(16'h0001, miss("R3"));
    // R4 valid flag clear
    wr(3, 0, 16'hABCD, 16'hFFFF, 0, act(0, 1, 5), 1, 100);
    srch(16'hABCD, miss("R4"));
    // R11 write and search same cycle
    @(negedge clk);
    sb.push_back(miss("R11"));
    wr_en = 1; wr_raw = 0; wr_idx = 2; wr_key = 16'h5555; wr_mask = 16'hFFFF;
    wr_valid = 1; wr_action = act(0, 1, 3); wr_rid_en = 0;
    srch_en = 1; srch_key = 16'h5555;
    @(negedge clk);
    wr_en = 0; srch_en = 0;
    srch(16'h5555, mk(1, 2, 0, 1, 3, 0, 0, "R11"));
    // R10 clear all, with a write in the same cycle
    @(negedge clk);
    clear_all = 1;
    wr_en = 1; wr_raw = 0; wr_idx = 4; wr_key = 16'h7777; wr_mask = 16'hFFFF;
    wr_valid = 1; wr_action = act(0, 1, 2);
    @(negedge clk);
    clear_all = 0; wr_en = 0;
    srch(16'h5555, miss("R10"));
    srch(16'h1234, miss("R10"));
    srch(16'h7777, miss("R10"));
    wr(6, 0, 16'h7777, 16'hFFFF, 1, act(0, 1, 2), 1, 4095);
    srch(16'h7777, mk(1, 6, 0, 1, 2, 1, 4095, "R10_R9"));
    @(negedge clk);
    chk("R6", "idle res_vld", res_vld, 0);
    repeat (2) @(negedge clk);
    chk("R6", "scoreboard empty", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule